// File: doc/BRIEF.md
# Saturating Pixel Pack Unit

This block is a pixel-formatting datapath for a partitioned media pipeline. It takes fixed-point lane data held in 64-bit operands and converts it to narrower pixel formats. The packing modes scale each lane by a field of a status word and then saturate the result. The other modes widen bytes into 16-bit lanes or interleave two 32-bit words byte by byte. A 3-bit opcode picks the mode. All arithmetic is combinational, and the result is captured in one output register stage.

An upstream issue stage presents both operands, the status word and the opcode together with a valid strobe. The result and its valid flag appear one clock later. Instruction decode and register-file access live outside the block. The status word is read only for its scale field, which starts at bit 3. The narrow pack uses 4 bits of that field; both 32-bit packs use 5.

Top module: `pxl_pack_unit`

## Requirements
- R1: The opcode, its inputs and the status word sampled on a clock edge with `in_valid` high produce `result` and `out_valid`=1 after that edge. After an edge with `in_valid` low, `out_valid` is 0. Reset clears `result` and `out_valid` to 0.
- R2: While `in_valid` is low, `result` keeps its previous value.
- R3: Opcode 0 (16-to-8 pack): scale = status[6:3]. Each signed 16-bit lane k of `opnd_b` is shifted left by scale and then arithmetically right by 7. The value is clamped to 0..255 and placed in result[8k+7:8k]. result[63:32] is 0.
- R4: Opcode 1 (32-to-8 pack with merge): scale = status[7:3]. The base is `opnd_a` shifted left by 8 with bits 7:0 and 39:32 cleared. For each signed 32-bit word k of `opnd_b`, ((word << scale) >>> 23) clamped to 0..255 is ORed into result[32k+7:32k].
- R5: Opcode 2 (32-to-16 pack): scale = status[7:3]. For each signed 32-bit word k of `opnd_b`, ((word << scale) >>> 16) clamped to -32768..32767 is placed in result[16k+15:16k]. result[63:32] is 0.
- R6: Opcode 3 (expand): each unsigned byte k of opnd_b[31:0] becomes 16-bit lane k of the result with value byte << 4, so the top 4 bits and the low 4 bits of each lane are 0.
- R7: Opcode 4 (interleave): result byte 2k = opnd_b byte k and result byte 2k+1 = opnd_a byte k, for k = 0..3.
- R8: Opcodes 5, 6 and 7 produce a result of all zeros with `out_valid` asserted.
- R9: Scaled intermediates never wrap. The largest positive and negative lanes, at the largest scale, saturate to the top and bottom of the output range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 3 | Mode select (0..4, others reserved) |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| status | input | 32 | Status word; scale field starts at bit 3 |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Registered formatted result |

## Verification
The hardest cases to reach are at the saturation edges. A lane must land exactly one step inside or outside the clamp range, or an extreme lane must meet the largest scale, where a narrow intermediate would silently wrap. Uniform random operands almost always saturate outright and rarely land in the linear region. The stimulus therefore mixes random traffic with directed lanes. These are built from small magnitudes and shifted by a chosen scale so that the fixed-point result lands on 255/256, -1/0 or 32767/32768. Opcode-major and minor-integer extremes are also paired with scale 31 and scale 15.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
   typedef enum logic [2:0] {
      OP_PACK16  = 3'd0,
      OP_PACK32B = 3'd1,
      OP_PACK32H = 3'd2,
      OP_EXPAND  = 3'd3,
      OP_MERGE   = 3'd4
   } pxl_op_e;
endpackage

// File: rtl/pxl_sat_lane.sv
module pxl_sat_lane #(
   parameter int IN_W       = 16,
   parameter int SCALE_W    = 4,
   parameter int FRAC       = 7,
   parameter int OUT_W      = 8,
   parameter bit SIGNED_OUT = 1'b0
) (
   input  logic [IN_W-1:0]    lane_i,
   input  logic [SCALE_W-1:0] scale_i,
   output logic [OUT_W-1:0]   sat_o
);
   localparam int W = IN_W + (1 << SCALE_W);
   localparam logic signed [W-1:0] HI = SIGNED_OUT ?
      W'((64'sd1 <<< (OUT_W-1)) - 64'sd1) : W'((64'sd1 <<< OUT_W) - 64'sd1);
   localparam logic signed [W-1:0] LO = SIGNED_OUT ? (-HI - W'(1)) : '0;

   if (OUT_W >= W || FRAC >= W) begin : g_bad_width
      $error("pxl_sat_lane: OUT_W/FRAC exceed intermediate width");
   end

   logic signed [W-1:0] ext, scaled, fixd;

   always_comb begin
      ext    = {{(W-IN_W){lane_i[IN_W-1]}}, lane_i};
      scaled = ext <<< scale_i;
      fixd   = scaled >>> FRAC;
      if (fixd < LO)      sat_o = OUT_W'(LO);
      else if (fixd > HI) sat_o = OUT_W'(HI);
      else                sat_o = OUT_W'(fixd);
   end
endmodule

// File: rtl/pxl_rearrange.sv
module pxl_rearrange #(
   parameter int BYTES = 4,
   parameter int PAD   = 4
) (
   input  logic [8*BYTES-1:0]  a_lo,
   input  logic [8*BYTES-1:0]  b_lo,
   output logic [16*BYTES-1:0] expand_o,
   output logic [16*BYTES-1:0] merge_o
);
   if (PAD > 8) begin : g_bad_pad
      $error("pxl_rearrange: PAD must not exceed 8");
   end

   for (genvar k = 0; k < BYTES; k++) begin : g_byte
      assign expand_o[16*k +: 16] = 16'({b_lo[8*k +: 8], PAD'(0)});
      assign merge_o[16*k +: 8]   = b_lo[8*k +: 8];
      assign merge_o[16*k+8 +: 8] = a_lo[8*k +: 8];
   end
endmodule

// File: rtl/pxl_pack_unit.sv
module pxl_pack_unit #(
   parameter int DATA_W         = 64,
   parameter int STAT_W         = 32,
   parameter int SCALE_LSB      = 3,
   parameter int NARROW_SCALE_W = 4,
   parameter int WIDE_SCALE_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [STAT_W-1:0] status,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);
   import pxl_pkg::*;

   localparam int HALF_W = DATA_W / 2;
   localparam int N16    = DATA_W / 16;
   localparam int N32    = DATA_W / 32;

   if (DATA_W != 64) begin : g_bad_data
      $error("pxl_pack_unit: DATA_W must be 64");
   end
   if (STAT_W < SCALE_LSB + WIDE_SCALE_W) begin : g_bad_stat
      $error("pxl_pack_unit: status word too narrow for scale field");
   end
   if (NARROW_SCALE_W > WIDE_SCALE_W) begin : g_bad_scale
      $error("pxl_pack_unit: narrow scale wider than wide scale");
   end

   logic [NARROW_SCALE_W-1:0] scale_n;
   logic [WIDE_SCALE_W-1:0]   scale_w;
   assign scale_n = status[SCALE_LSB +: NARROW_SCALE_W];
   assign scale_w = status[SCALE_LSB +: WIDE_SCALE_W];

   logic [HALF_W-1:0] pk16_v;
   logic [DATA_W-1:0] pk32b_v;
   logic [HALF_W-1:0] pk32h_v;
   logic [DATA_W-1:0] exp_v, mrg_v;
   logic [DATA_W-1:0] pk32b_base;

   for (genvar k = 0; k < N16; k++) begin : g_pack16
      pxl_sat_lane #(.IN_W(16), .SCALE_W(NARROW_SCALE_W), .FRAC(7),
                     .OUT_W(8), .SIGNED_OUT(1'b0)) u_lane (
         .lane_i (opnd_b[16*k +: 16]),
         .scale_i(scale_n),
         .sat_o  (pk16_v[8*k +: 8])
      );
   end

   assign pk32b_base = (opnd_a << 8) & ~{N32{{(HALF_W-8){1'b0}}, 8'hff}};

   for (genvar k = 0; k < N32; k++) begin : g_pack32
      logic [7:0]  byte_s;
      logic [15:0] half_s;
      pxl_sat_lane #(.IN_W(32), .SCALE_W(WIDE_SCALE_W), .FRAC(23),
                     .OUT_W(8), .SIGNED_OUT(1'b0)) u_byte (
         .lane_i (opnd_b[32*k +: 32]),
         .scale_i(scale_w),
         .sat_o  (byte_s)
      );
      pxl_sat_lane #(.IN_W(32), .SCALE_W(WIDE_SCALE_W), .FRAC(16),
                     .OUT_W(16), .SIGNED_OUT(1'b1)) u_half (
         .lane_i (opnd_b[32*k +: 32]),
         .scale_i(scale_w),
         .sat_o  (half_s)
      );
      assign pk32b_v[32*k +: 32] = pk32b_base[32*k +: 32] | {24'd0, byte_s};
      assign pk32h_v[16*k +: 16] = half_s;
   end

   pxl_rearrange #(.BYTES(HALF_W/8), .PAD(4)) u_rearr (
      .a_lo    (opnd_a[HALF_W-1:0]),
      .b_lo    (opnd_b[HALF_W-1:0]),
      .expand_o(exp_v),
      .merge_o (mrg_v)
   );

   logic [DATA_W-1:0] next_res;
   always_comb begin
      unique case (pxl_op_e'(op))
         OP_PACK16:  next_res = {{HALF_W{1'b0}}, pk16_v};
         OP_PACK32B: next_res = pk32b_v;
         OP_PACK32H: next_res = {{HALF_W{1'b0}}, pk32h_v};
         OP_EXPAND:  next_res = exp_v;
         OP_MERGE:   next_res = mrg_v;
         default:    next_res = '0;
      endcase
   end

   logic unused_bits;
   assign unused_bits = ^{status};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= next_res;
      end
   end
endmodule

// File: rtl/pxl_pack_checker.sv
module pxl_pack_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [2:0]  op,
   input logic [63:0] opnd_a,
   input logic [63:0] opnd_b,
   input logic        out_valid,
   input logic [63:0] result
);
   p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
   p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd0) |=> result[63:32] == 32'd0);
   p_merge_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd1) |=> (result[15:8] == $past(opnd_a[7:0])
                                    && result[47:40] == $past(opnd_a[39:32])));
   p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd2) |=> result[63:32] == 32'd0);
   p_expand_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd3) |=> (result[15:12] == 4'd0 && result[3:0] == 4'd0
                                    && result[11:4] == $past(opnd_b[7:0])));
   p_interleave_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd4) |=> (result[7:0] == $past(opnd_b[7:0])
                                    && result[63:56] == $past(opnd_a[31:24])));
   p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op > 3'd4) |=> result == 64'd0);
endmodule

bind pxl_pack_unit pxl_pack_checker u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
   .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result)
);

// File: tb/tb_pxl_pack_unit.sv
module tb_pxl_pack_unit;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op = '0;
   logic [63:0] opnd_a = '0, opnd_b = '0;
   logic [31:0] status = '0;
   logic        out_valid;
   logic [63:0] result;

   int n_cmp = 0, n_bad = 0;
   logic        exp_valid = 1'b0;
   logic [63:0] exp_res = '0;
   string       exp_tag = "R1";
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pxl_pack_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .status(status),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic [63:0] model(input logic [2:0] o, input logic [63:0] a,
                                         input logic [63:0] b, input logic [31:0] st);
      logic [63:0] r = '0;
      int sc16 = int'(st[6:3]);
      int sc32 = int'(st[7:3]);
      case (o)
         3'd0: for (int k = 0; k < 4; k++) begin
            int v = int'($signed(b[16*k +: 16]));
            v = (v <<< sc16) >>> 7;
            if (v < 0) v = 0; else if (v > 255) v = 255;
            r[8*k +: 8] = 8'(v);
         end
         3'd1: begin
            r = (a << 8) & ~64'h0000_00ff_0000_00ff;
            for (int k = 0; k < 2; k++) begin
               longint v = longint'($signed(b[32*k +: 32]));
               v = (v <<< sc32) >>> 23;
               if (v < 0) v = 0; else if (v > 255) v = 255;
               r[32*k +: 8] = r[32*k +: 8] | 8'(v);
            end
         end
         3'd2: for (int k = 0; k < 2; k++) begin
            longint v = longint'($signed(b[32*k +: 32]));
            v = (v <<< sc32) >>> 16;
            if (v < -32768) v = -32768; else if (v > 32767) v = 32767;
            r[16*k +: 16] = 16'(v);
         end
         3'd3: for (int k = 0; k < 4; k++) r[16*k +: 16] = {4'd0, b[8*k +: 8], 4'd0};
         3'd4: for (int k = 0; k < 4; k++) begin
            r[16*k +: 8]   = b[8*k +: 8];
            r[16*k+8 +: 8] = a[8*k +: 8];
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string tag_of(input logic [2:0] o);
      case (o)
         3'd0: return "R3";
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic compare();
      n_cmp++;
      if (out_valid !== exp_valid) begin
         n_bad++;
         $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
      end
      n_cmp++;
      if (result !== exp_res) begin
         n_bad++;
         $display("FAIL %s result actual=%h expected=%h", exp_tag, result, exp_res);
      end
   endtask

   task automatic step(input logic v, input logic [2:0] o, input logic [63:0] a,
                       input logic [63:0] b, input logic [31:0] st, input string tg);
      @(negedge clk);
      compare();
      in_valid = v; op = o; opnd_a = a; opnd_b = b; status = st;
      exp_valid = v;
      if (v) begin
         exp_res = model(o, a, b, st);
         exp_tag = tg;
      end else begin
         exp_tag = "R2";
      end
   endtask

   function automatic logic [31:0] st_scale(input int s);
      return 32'(s) << 3;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      exp_tag = "R1";
      compare();
      rst_n = 1'b1;
      // R1 reset state and idle
      step(1'b0, 3'd0, '0, '0, '0, "R1");
      step(1'b0, 3'd0, '0, '0, '0, "R1");
      // R3 linear, boundary and clamp
      step(1'b1, 3'd0, '0, {16'h0080, 16'h7f80, 16'h0100, 16'hff80}, st_scale(0), "R3");
      step(1'b1, 3'd0, '0, {16'h0001, 16'h0002, 16'hffff, 16'h0000}, st_scale(15), "R3");
      step(1'b1, 3'd0, '0, {16'h7fff, 16'h8000, 16'h0101, 16'h00ff}, st_scale(1), "R3");
      step(1'b1, 3'd0, '0, 64'h1234_5678_9abc_def0, 32'hffff_ff87, "R3");
      // R2 hold
      step(1'b0, 3'd4, 64'hdead, 64'hbeef, '0, "R2");
      step(1'b0, 3'd1, '1, '1, '1, "R2");
      // R4 merge pack
      step(1'b1, 3'd1, 64'h1122_3344_5566_7788, {32'h0000_8000, 32'h7f80_0000}, st_scale(0), "R4");
      step(1'b1, 3'd1, 64'hffff_ffff_ffff_ffff, {32'h0000_0001, 32'hffff_ffff}, st_scale(31), "R4");
      step(1'b1, 3'd1, 64'h0, {32'h0000_0080, 32'h0000_0081}, st_scale(16), "R4");
      // R5 halfword pack
      step(1'b1, 3'd2, '0, {32'h7fff_0000, 32'h8000_0000}, st_scale(0), "R5");
      step(1'b1, 3'd2, '0, {32'h0000_4000, 32'hffff_c000}, st_scale(1), "R5");
      step(1'b1, 3'd2, '0, {32'h0000_8000, 32'hffff_7fff}, st_scale(16), "R5");
      // R6 expand
      step(1'b1, 3'd3, '1, 64'hffff_ffff_ff00_a55a, '0, "R6");
      // R7 interleave
      step(1'b1, 3'd4, 64'h9999_9999_a1b2_c3d4, 64'h8888_8888_0102_0304, '0, "R7");
      // R8 reserved
      for (int o = 5; o < 8; o++) step(1'b1, 3'(o), '1, '1, '1, "R8");
      // R9 extremes at largest scale
      step(1'b1, 3'd1, '0, {32'h7fff_ffff, 32'h8000_0000}, st_scale(31), "R9");
      step(1'b1, 3'd2, '0, {32'h7fff_ffff, 32'h8000_0000}, st_scale(31), "R9");
      step(1'b1, 3'd2, '0, {32'h8000_0000, 32'h7fff_ffff}, st_scale(31), "R9");
      step(1'b1, 3'd0, '0, {16'h7fff, 16'h8000, 16'h8000, 16'h7fff}, st_scale(15), "R9");
      step(1'b1, 3'd1, '0, {32'h0000_0001, 32'h0000_0002}, st_scale(30), "R9");
      // random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [2:0]  ro = 3'($urandom_range(0, 7));
         logic        rv = ($urandom_range(0, 3) != 0);
         logic [63:0] ra = {$urandom, $urandom};
         logic [63:0] rb = {$urandom, $urandom};
         logic [31:0] rs = $urandom;
         if (i % 3 == 0) begin
            for (int k = 0; k < 4; k++)
               rb[16*k +: 16] = 16'($signed(8'($urandom)));
         end
         step(rv, ro, ra, rb, rs, tag_of(ro));
      end
      step(1'b0, 3'd0, '0, '0, '0, "R2");
      step(1'b0, 3'd0, '0, '0, '0, "R2");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R1 watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule